// File: doc/BRIEF.md
# PC Card Access Timing Sequencer

This block sequences one access at a time to either of two PC Card slots. Each slot has three address spaces: I/O, attribute and common memory. A 32-bit configuration word holds a 5-bit tick-length count for every slot/space pair and a fast-setup flag for each slot. When a request is accepted, the block captures the count N that matches the request. It then advances its sequence on an internal tick that fires once every N+1 clocks. The tick is never brought out of the block. The sequence drives the address-type qualifiers (slot enable, register select, upper-half marker), then the read or write strobe of the right kind, then holds the address for a while before it returns to idle.

A card can stretch the strobe through an asynchronous wait input. That input is resynchronised by two flops before the sequencer looks at it. A 16-bit I/O request to a card that does not report 16-bit I/O capability is carried out as two 8-bit halves. The second half has a setup phase of its own length.

The state machine has six states:
- `ST_IDLE` waits for a request.
- `ST_LEAD` is the one-clock lead-in after acceptance.
- `ST_SETUP` counts setup ticks.
- `ST_STROBE` drives the strobe.
- `ST_HOLD` keeps the address for one tick after the strobe.
- `ST_FIN` is the one-clock completion state.

It moves through these transitions:
- accept: IDLE to LEAD.
- lead: LEAD to SETUP.
- setup-done: SETUP to STROBE.
- strobe-stretch: STROBE to STROBE on wait.
- strobe-done: STROBE to HOLD.
- next-half: HOLD to SETUP, for the second half of a split.
- hold-done: HOLD to FIN.
- release: FIN to IDLE.

Top module: `pcc_timing_seq`

## Requirements
- R1: The count N is taken from configuration bits [s*16+4:s*16] for I/O (space code 00), [s*16+9:s*16+5] for attribute (01), and [s*16+14:s*16+10] for common memory (10 and 11), where s is the slot number. `slot_en` is one-hot on the addressed slot, and `reg_sel` is high for the I/O and attribute spaces.
- R2: Every setup, strobe and hold phase lasts a whole number of ticks, and one tick is N+1 clocks.
- R3: With the slot's fast flag clear, `addr_act` is high for 3*(N+1)+1 clocks before the strobe rises. Acceptance is the clock edge at which `req_valid` is sampled high while `busy` is low, and `addr_act` rises at that edge.
- R4: With the fast flag set, that setup is (N+1)+1 clocks. Slot 0's fast flag is configuration bit 15 and slot 1's is bit 31.
- R5: Without wait, the strobe stays high for exactly 3*(N+1) clocks, whatever the fast flag is.
- R6: Memory and attribute accesses drive `mem_we` for writes and `mem_oe` for reads. I/O accesses drive `io_wr` or `io_rd`. At most one strobe is high at a time, and only while `addr_act` is high.
- R7: `card_wait` passes through a two-flop synchronizer. If its synchronized value is high at the tick that would end the strobe, the strobe is extended by one more tick, and this is repeated until it reads low.
- R8: After the strobe falls, `addr_act` stays high for N+1 clocks. Then `done` is high for exactly one clock with `busy` still high, and `busy` falls on the next clock.
- R9: An I/O request with `req_wide`=1 and `card_io16`=0 runs as two halves. After the first half's hold, `half_hi` rises and `addr_act` stays high for 2*(N+1) clocks before a second strobe of 3*(N+1) clocks, followed by a second hold.
- R10: A wide I/O request with `card_io16`=1, and any wide memory or attribute request, completes in one half with no split.
- R11: While `rst_n` is low, and after reset, `busy`, `done`, `addr_act` and all strobes are low. The configuration word itself is not reset.
- R12: While `busy` is high, `req_valid` is ignored. A configuration write during an access does not change that access's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | New configuration word |
| req_valid | input | 1 | Request an access (taken when not busy) |
| req_slot | input | 1 | Target slot 0 or 1 |
| req_space | input | 2 | 00 I/O, 01 attribute, 10/11 common memory |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wide | input | 1 | 16-bit access |
| card_io16 | input | 1 | Card accepts 16-bit I/O, captured at acceptance |
| card_wait | input | 1 | Asynchronous wait request from the card |
| busy | output | 1 | Sequencer not idle |
| addr_act | output | 1 | Address-type signals are being driven |
| slot_en | output | 2 | One-hot card enable per slot |
| reg_sel | output | 1 | Register-space select (I/O or attribute) |
| half_hi | output | 1 | Second half of a split I/O access |
| mem_we | output | 1 | Memory/attribute write strobe |
| mem_oe | output | 1 | Memory/attribute read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_rd | output | 1 | I/O read strobe |
| done | output | 1 | One-clock completion pulse |

## Verification
`addr_act` rises at the acceptance edge. The strobe follows 1+k*(N+1) clocks later, where k is 3, 1 or (for a second half) 2 ticks, and `done` comes N+1 clocks after the strobe falls. A wait change reaches the sequencer two edges after it is driven and takes effect only at the next tick boundary. The bench drives inputs on falling edges and holds a behavioural countdown model of the expected phase, updated on each rising edge. It compares every output against that model at each falling edge. Separate per-access measurements count falling edges in each phase and compare the counts with the formulas above.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
package pcc_pkg;
    localparam int CNT_W       = 5;
    localparam int NUM_SLOTS   = 2;
    localparam int SLOT_STRIDE = 16;
    localparam int CFG_W       = NUM_SLOTS * SLOT_STRIDE;
    localparam int PH_W        = 2;

    typedef enum logic [1:0] {
        SP_IO   = 2'b00,
        SP_ATTR = 2'b01,
        SP_MEM  = 2'b10,
        SP_MEM2 = 2'b11
    } space_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_FIN
    } seq_state_e;

    localparam logic [PH_W-1:0] TICKS_NORMAL = 2'd3;
    localparam logic [PH_W-1:0] TICKS_FAST   = 2'd1;
    localparam logic [PH_W-1:0] TICKS_HALF2  = 2'd2;
    localparam logic [PH_W-1:0] TICKS_STROBE = 2'd3;
endpackage

// File: rtl/pcc_field_sel.sv
`timescale 1ns/1ps
module pcc_field_sel
    import pcc_pkg::*;
#(
    parameter int W      = CNT_W,
    parameter int SLOTS  = NUM_SLOTS,
    parameter int STRIDE = SLOT_STRIDE,
    localparam int CW    = SLOTS * STRIDE,
    localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [CW-1:0] cfg,
    input  logic [SW-1:0] slot,
    input  space_e        space,
    output logic [W-1:0]  count,
    output logic          fast
);
    logic [W-1:0] io_f   [SLOTS];
    logic [W-1:0] attr_f [SLOTS];
    logic [W-1:0] mem_f  [SLOTS];
    logic [SLOTS-1:0] fast_f;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign io_f[s]   = cfg[s*STRIDE        +: W];
        assign attr_f[s] = cfg[s*STRIDE + W    +: W];
        assign mem_f[s]  = cfg[s*STRIDE + 2*W  +: W];
        assign fast_f[s] = cfg[s*STRIDE + STRIDE - 1];
    end

    always_comb begin
        unique case (space)
            SP_IO:   count = io_f[slot];
            SP_ATTR: count = attr_f[slot];
            default: count = mem_f[slot];
        endcase
        fast = fast_f[slot];
    end
endmodule

// File: rtl/pcc_tick_gen.sv
`timescale 1ns/1ps
module pcc_tick_gen #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pcc_wait_sync.sv
`timescale 1ns/1ps
module pcc_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pcc_timing_seq.sv
`timescale 1ns/1ps
module pcc_timing_seq
    import pcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    input  logic        req_valid,
    input  logic        req_slot,
    input  logic [1:0]  req_space,
    input  logic        req_write,
    input  logic        req_wide,
    input  logic        card_io16,
    input  logic        card_wait,
    output logic        busy,
    output logic        addr_act,
    output logic [1:0]  slot_en,
    output logic        reg_sel,
    output logic        half_hi,
    output logic        mem_we,
    output logic        mem_oe,
    output logic        io_wr,
    output logic        io_rd,
    output logic        done
);
    // configuration word: deliberately without reset
    logic [CFG_W-1:0] cfg_q;
    always_ff @(posedge clk) begin
        if (cfg_we)
            cfg_q <= cfg_wdata;
    end

    logic [CNT_W-1:0] sel_cnt;
    logic             sel_fast;
    pcc_field_sel u_fsel (
        .cfg   (cfg_q),
        .slot  (req_slot),
        .space (space_e'(req_space)),
        .count (sel_cnt),
        .fast  (sel_fast)
    );

    logic wait_s;
    pcc_wait_sync #(.STAGES(2)) u_wsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (card_wait),
        .sync_out (wait_s)
    );

    seq_state_e       state_q, state_d;
    logic [PH_W-1:0]  ph_q, ph_d;
    logic             half_q, half_d;
    logic             l_slot, l_write, l_split, l_fast;
    space_e           l_space;
    logic [CNT_W-1:0] l_cnt;
    logic             accept;
    logic             tick;
    logic             tick_run;
    logic [PH_W-1:0]  setup_last;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign tick_run = (state_q == ST_SETUP) || (state_q == ST_STROBE) ||
                      (state_q == ST_HOLD);

    pcc_tick_gen #(.W(CNT_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tick_run),
        .limit (l_cnt),
        .tick  (tick)
    );

    always_comb begin
        if (half_q)
            setup_last = TICKS_HALF2 - 1'b1;
        else if (l_fast)
            setup_last = TICKS_FAST - 1'b1;
        else
            setup_last = TICKS_NORMAL - 1'b1;
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_slot  <= 1'b0;
            l_space <= SP_IO;
            l_write <= 1'b0;
            l_split <= 1'b0;
            l_fast  <= 1'b0;
            l_cnt   <= '0;
        end else if (accept) begin
            l_slot  <= req_slot;
            l_space <= space_e'(req_space);
            l_write <= req_write;
            l_split <= (space_e'(req_space) == SP_IO) && req_wide && !card_io16;
            l_fast  <= sel_fast;
            l_cnt   <= sel_cnt;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        half_d  = half_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_LEAD;
                    half_d  = 1'b0;
                end
            end
            ST_LEAD: begin
                state_d = ST_SETUP;
                ph_d    = '0;
            end
            ST_SETUP: begin
                if (tick) begin
                    if (ph_q == setup_last) begin
                        state_d = ST_STROBE;
                        ph_d    = '0;
                    end else begin
                        ph_d = ph_q + 1'b1;
                    end
                end
            end
            ST_STROBE: begin
                if (tick) begin
                    if (ph_q == TICKS_STROBE - 1'b1) begin
                        if (!wait_s) begin
                            state_d = ST_HOLD;
                            ph_d    = '0;
                        end
                    end else begin
                        ph_d = ph_q + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    if (l_split && !half_q) begin
                        state_d = ST_SETUP;
                        half_d  = 1'b1;
                        ph_d    = '0;
                    end else begin
                        state_d = ST_FIN;
                    end
                end
            end
            ST_FIN: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            half_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            half_q  <= half_d;
        end
    end

    // outputs
    always_comb begin
        logic act, stb, is_io;
        act      = (state_q == ST_LEAD) || (state_q == ST_SETUP) ||
                   (state_q == ST_STROBE) || (state_q == ST_HOLD);
        stb      = (state_q == ST_STROBE);
        is_io    = (l_space == SP_IO);
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_FIN);
        addr_act = act;
        slot_en  = act ? (l_slot ? 2'b10 : 2'b01) : 2'b00;
        reg_sel  = act && ((l_space == SP_IO) || (l_space == SP_ATTR));
        half_hi  = act && half_q;
        mem_we   = stb && !is_io && l_write;
        mem_oe   = stb && !is_io && !l_write;
        io_wr    = stb && is_io && l_write;
        io_rd    = stb && is_io && !l_write;
    end
endmodule

// File: rtl/pcc_seq_chk.sv
`timescale 1ns/1ps
module pcc_seq_chk #(
    parameter int W = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         addr_act,
    input logic         half_hi,
    input logic         mem_we,
    input logic         mem_oe,
    input logic         io_wr,
    input logic         io_rd,
    input logic         done,
    input logic [W-1:0] cnt
);
    logic any_stb;
    int   stb_len;
    assign any_stb = mem_we || mem_oe || io_wr || io_rd;

    always_ff @(posedge clk) begin
        if (!rst_n)
            stb_len <= 0;
        else if (any_stb)
            stb_len <= stb_len + 1;
        else
            stb_len <= 0;
    end

    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_oe, io_wr, io_rd}));

    // R6
    strobe_in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> addr_act);

    // R3
    setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_stb) |-> $past(addr_act));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    // R5
    strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_stb) |-> ((stb_len % (int'(cnt) + 1)) == 0 &&
                            stb_len >= 3 * (int'(cnt) + 1)));

    // R9
    half_in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_hi) |-> $past(addr_act) && !any_stb);
endmodule

bind pcc_timing_seq pcc_seq_chk #(.W(pcc_pkg::CNT_W)) u_seq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .addr_act (addr_act),
    .half_hi  (half_hi),
    .mem_we   (mem_we),
    .mem_oe   (mem_oe),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .done     (done),
    .cnt      (l_cnt)
);

// File: tb/tb_pcc_timing_seq.sv
`timescale 1ns/1ps
module tb_pcc_timing_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_slot = 1'b0;
    logic [1:0]  req_space = 2'b00;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic        card_io16 = 1'b0;
    logic        card_wait = 1'b0;
    logic        busy, addr_act, reg_sel, half_hi;
    logic        mem_we, mem_oe, io_wr, io_rd, done;
    logic [1:0]  slot_en;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    pcc_timing_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_slot(req_slot), .req_space(req_space),
        .req_write(req_write), .req_wide(req_wide), .card_io16(card_io16),
        .card_wait(card_wait), .busy(busy), .addr_act(addr_act),
        .slot_en(slot_en), .reg_sel(reg_sel), .half_hi(half_hi),
        .mem_we(mem_we), .mem_oe(mem_oe), .io_wr(io_wr), .io_rd(io_rd),
        .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int field_n(input logic [31:0] c, input bit s, input logic [1:0] sp);
        int base = s ? 16 : 0;
        if (sp == 2'b00) return int'(c[base +: 5]);
        if (sp == 2'b01) return int'(c[base + 5 +: 5]);
        return int'(c[base + 10 +: 5]);
    endfunction

    function automatic logic [31:0] mk_cfg(input int i0, a0, m0, f0, i1, a1, m1, f1);
        logic [15:0] lo, hi;
        lo = 16'(i0) | (16'(a0) << 5) | (16'(m0) << 10) | (16'(f0) << 15);
        hi = 16'(i1) | (16'(a1) << 5) | (16'(m1) << 10) | (16'(f1) << 15);
        return {hi, lo};
    endfunction

    // behavioural reference: phase 0 idle,1 lead,2 setup,3 strobe,4 hold,5 fin
    logic [31:0] cfg_m;
    int  ph = 0, rem = 0, mn = 0;
    bit  mhalf = 0, msplit = 0, mf = 0, ms = 0, mw = 0, m1 = 0, m2 = 0, wv = 0;
    logic [1:0] msp = 2'b00;
    bit  started = 0;

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            ph = 0; rem = 0; mhalf = 0; m1 = 0; m2 = 0;
        end else begin
            wv = m2; m2 = m1; m1 = card_wait;
            case (ph)
                0: if (req_valid) begin
                    ms = req_slot; msp = req_space; mw = req_write;
                    msplit = (req_space == 2'b00) && req_wide && !card_io16;
                    mn = field_n(cfg_m, req_slot, req_space);
                    mf = req_slot ? cfg_m[31] : cfg_m[15];
                    mhalf = 0; ph = 1;
                end
                1: begin ph = 2; rem = mf ? (mn + 1) : 3 * (mn + 1); end
                2: begin rem--; if (rem == 0) begin ph = 3; rem = 3 * (mn + 1); end end
                3: begin
                    rem--;
                    if (rem == 0) begin
                        rem = mn + 1;
                        if (!wv) ph = 4;
                    end
                end
                4: begin
                    rem--;
                    if (rem == 0) begin
                        if (msplit && !mhalf) begin mhalf = 1; ph = 2; rem = 2 * (mn + 1); end
                        else ph = 5;
                    end
                end
                default: ph = 0;
            endcase
            if (cfg_we) cfg_m = cfg_wdata;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            bit act, stb, io;
            logic [1:0] e_slot;
            act = (ph >= 1 && ph <= 4);
            stb = (ph == 3);
            io  = (msp == 2'b00);
            e_slot = act ? (ms ? 2'b10 : 2'b01) : 2'b00;
            chk({busy, done} == {ph != 0, ph == 5}, "R8 busy/done", int'({busy, done}),
                int'({ph != 0, ph == 5}));
            chk({addr_act, slot_en, reg_sel} == {act, e_slot, act && (msp == 2'b00 || msp == 2'b01)},
                "R1 addr/slot/regsel", int'({addr_act, slot_en, reg_sel}),
                int'({act, e_slot, act && (msp == 2'b00 || msp == 2'b01)}));
            chk(half_hi == (act && mhalf), "R9 half_hi", int'(half_hi), int'(act && mhalf));
            chk({mem_we, mem_oe, io_wr, io_rd} ==
                {stb && !io && mw, stb && !io && !mw, stb && io && mw, stb && io && !mw},
                "R6 strobes", int'({mem_we, mem_oe, io_wr, io_rd}),
                int'({stb && !io && mw, stb && !io && !mw, stb && io && mw, stb && io && !mw}));
        end
    end

    // wait stimulus: held by wait_req, dropped after release_at strobe clocks
    bit wait_req = 0;
    int release_at = 0;
    int sc = 0;
    always @(negedge clk) begin
        if (mem_we || mem_oe || io_wr || io_rd) sc++; else sc = 0;
        card_wait = wait_req && !(release_at != 0 && sc >= release_at);
    end

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_access(input bit s, input logic [1:0] sp, input bit wr, input bit wide,
                             input bit io16, input int e_su, input int e_st, input int n1,
                             input bit e_split, input string tag, input bit disturb);
        int su = 0, st = 0, h1 = 0, su2 = 0, st2 = 0, h2 = 0, dn = 0;
        @(negedge clk);
        req_slot = s; req_space = sp; req_write = wr; req_wide = wide; card_io16 = io16;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (addr_act && !(mem_we || mem_oe || io_wr || io_rd)) begin
            su++;
            if (disturb && su == 2) begin
                req_valid = 1'b1; req_space = 2'b10; cfg_we = 1'b1; cfg_wdata = '0;
            end else begin
                req_valid = 1'b0; cfg_we = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0; cfg_we = 1'b0;
        while (mem_we || mem_oe || io_wr || io_rd) begin st++; @(negedge clk); end
        while (addr_act && !half_hi && !(mem_we || mem_oe || io_wr || io_rd)) begin
            h1++; @(negedge clk);
        end
        if (e_split) begin
            while (addr_act && !(mem_we || mem_oe || io_wr || io_rd)) begin su2++; @(negedge clk); end
            while (mem_we || mem_oe || io_wr || io_rd) begin st2++; @(negedge clk); end
            while (addr_act) begin h2++; @(negedge clk); end
        end
        while (busy) begin if (done) dn++; @(negedge clk); end
        chk(su == e_su, {tag, " setup clocks"}, su, e_su);
        chk(st == e_st, {tag, " strobe clocks"}, st, e_st);
        chk(h1 == n1, {tag, " R8 hold clocks"}, h1, n1);
        chk(dn == 1, {tag, " R8 done pulse"}, dn, 1);
        if (e_split) begin
            chk(su2 == 2 * n1, {tag, " R9 second setup"}, su2, 2 * n1);
            chk(st2 == 3 * n1, {tag, " R9 second strobe"}, st2, 3 * n1);
            chk(h2 == n1, {tag, " R9 second hold"}, h2, n1);
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] base_cfg;
        base_cfg = mk_cfg(1, 2, 3, 0, 0, 4, 2, 1);
        repeat (3) @(negedge clk);
        // R11: reset state
        chk({busy, done, addr_act, mem_we, mem_oe, io_wr, io_rd} == 7'b0, "R11 reset outputs",
            int'({busy, done, addr_act, mem_we, mem_oe, io_wr, io_rd}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !addr_act, "R11 idle after reset", int'({busy, addr_act}), 0);
        write_cfg(base_cfg);

        // R1 R3 R5 R6: slot0 memory read, N=3
        do_access(1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 13, 12, 4, 1'b0, "R3 R5 s0 mem rd", 1'b0);
        // R1 R2 R6: slot0 attribute write, N=2
        do_access(1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 10, 9, 3, 1'b0, "R1 R2 s0 attr wr", 1'b0);
        // R1 R6: slot0 I/O read narrow, N=1
        do_access(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 7, 6, 2, 1'b0, "R1 s0 io rd", 1'b0);
        // R4 R5: slot1 memory write, fast via bit 31, N=2
        do_access(1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 4, 9, 3, 1'b0, "R4 R5 s1 mem wr fast", 1'b0);
        // R9: slot1 wide I/O to 8-bit card, N=0, fast
        do_access(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 2, 3, 1, 1'b1, "R9 s1 io split", 1'b0);
        // R10: wide I/O to 16-bit card, no split
        do_access(1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 7, 6, 2, 1'b0, "R10 s0 io16", 1'b0);
        // R10: wide attribute access, no split, N=4 fast
        do_access(1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 6, 15, 5, 1'b0, "R10 s1 attr wide", 1'b0);

        // R7: wait held, released after 13 strobe clocks -> one extra tick (N=3)
        wait_req = 1; release_at = 13;
        do_access(1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 13, 16, 4, 1'b0, "R7 wait stretch", 1'b0);
        wait_req = 0; release_at = 0;

        // R12: request and config write while busy are ignored
        do_access(1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 7, 6, 2, 1'b0, "R12 busy ignore", 1'b1);
        repeat (5) @(negedge clk);
        chk(!busy && !addr_act, "R12 no second access", int'({busy, addr_act}), 0);

        // R4: slot0 fast flag at bit 15, N=3
        write_cfg(base_cfg | 32'h0000_8000);
        do_access(1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 5, 12, 4, 1'b0, "R4 s0 fast bit15", 1'b0);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule